// File: doc/BRIEF.md
# NOR Flash Read-Path Selector

This block sits on the read side of a parallel NOR flash controller and decides what a bus read returns. The command decoder next to it holds the current command mode and passes in its code. From that code this block picks one of four sources. The first is the storage array, with bytes packed by access width and byte order. The second is the identification words used in autoselect. The third is a status byte whose bit 6 flips on every poll. The fourth is a built-in query table that describes the device geometry.

The block owns the status byte. The command decoder can load the status byte, and an erase-timer expiry flips its bit 7. Every read is registered: the result and a valid pulse appear one clock after the read strobe. The storage array sits outside the block and is reached through a synchronous read port. That port returns four consecutive bytes one clock after the address. When the mode code is not one the block recognises, the read is served from the array and a one-cycle request tells the decoder to return to idle.

Top module: `nor_read_mux`

## Requirements
- R1: `rdValid` is high exactly in the cycle after a cycle with `rdEn` high, and `rdData` carries that read's result while `rdValid` is high.
- R2: In mode 0x00 (plain read) and in mode 0x80 (erase set-up), the array bytes at addresses A, A+1, A+2 and A+3 are returned by `rdSize`: 0 gives one byte, 1 gives two bytes, 2 or 3 gives four bytes. Any unused upper bits are zero. With `bigEndian` low, byte A lands in bits 7:0. With `bigEndian` high, byte A lands in the most significant byte of the selected width.
- R3: The array address equals the bus address masked to the chip size (SECTOR_BYTES*SECTOR_COUNT), so reads above the chip size mirror the chip.
- R4: The table offset used by autoselect and query reads is `rdAddr[7:0]` shifted right by 1 when DEV_BYTES is 2, by 2 when DEV_BYTES is 4, and not shifted when DEV_BYTES is 1.
- R5: In mode 0x90, offset 0 returns `idWord0`, offset 1 returns `idWord1`, and offset 2 returns zero. The ID words are zero-extended to 32 bits.
- R6: In mode 0x90, offset 0x0E returns `idWord2` and offset 0x0F returns `idWord3`, unless the low byte of the selected word is 0xFF, in which case array data is returned. Every other offset also returns array data.
- R7: In modes 0xA0, 0x10 and 0x30 a read returns the status byte, zero-extended. Each such read then inverts status bit 6, so the next poll sees the opposite bit 6.
- R8: The status byte resets to 0x00. `statusLoadEn` replaces it with `statusLoadVal` and takes priority over any toggle in that cycle. Each cycle with `busyDone` high inverts bit 7.
- R9: In mode 0x98, offsets below 0x52 return the query-table byte and offsets at or above 0x52 return zero. The table holds 0x51 ('Q') at 0x10, log2 of the chip size at 0x27, 0x01 at 0x2C, and the sector count minus one at 0x2D (low byte).
- R10: Any mode code other than 0x00, 0x80, 0x90, 0xA0, 0x10, 0x30 or 0x98 is read as mode 0x00. `modeClear` pulses high in the same cycle as that read's `rdValid` and is low otherwise.
- R11: After reset `rdValid` and `modeClear` are low until a read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdEn | input | 1 | Read strobe, one cycle per read |
| rdAddr | input | ADDR_W | Bus byte address of the read |
| rdSize | input | 2 | Access width: 0 one byte, 1 two bytes, 2/3 four bytes |
| bigEndian | input | 1 | Byte-order strap for array reads |
| modeCode | input | 8 | Current command mode from the decoder |
| idWord0 | input | 16 | Identification word for offset 0 |
| idWord1 | input | 16 | Identification word for offset 1 |
| idWord2 | input | 16 | Identification word for offset 0x0E |
| idWord3 | input | 16 | Identification word for offset 0x0F |
| statusLoadEn | input | 1 | Load the status byte |
| statusLoadVal | input | 8 | Value for a status load |
| busyDone | input | 1 | Erase busy period ended; inverts status bit 7 |
| arrRdEn | output | 1 | Array read request |
| arrAddr | output | CHIP_AW | Masked array byte address |
| arrData | input | 32 | Array bytes A..A+3 in lanes 0..3, one cycle after request |
| rdData | output | 32 | Read result |
| rdValid | output | 1 | Read result valid |
| modeClear | output | 1 | Request to return the mode to idle after an unknown code |

## Verification
The bench checks lane placement for every width in both byte orders, because a swapped or unmasked lane would return a scrambled word. It covers the boundaries of the ID fallback: words whose low byte is 0xFF, and offsets that are not listed. A design that always trusted the ID word here would return 0x00FF instead of array data. It polls the status register several times in a row and mixes in loads and busy expiries; a design that toggled on the wrong edge, or let a toggle override a load, would break the expected bit-6/bit-7 sequence. It also reads the query table at both sides of its end (0x51, 0x52) and reads above the chip size, where a missing length check or address mask would return stale table or array bytes.

// File: rtl/nor_rd_pkg.sv
package nor_rd_pkg;

  localparam logic [7:0] MODE_READ         = 8'h00;
  localparam logic [7:0] MODE_ERASE_SETUP  = 8'h80;
  localparam logic [7:0] MODE_AUTOSEL      = 8'h90;
  localparam logic [7:0] MODE_PROGRAM      = 8'hA0;
  localparam logic [7:0] MODE_CHIP_ERASE   = 8'h10;
  localparam logic [7:0] MODE_SECTOR_ERASE = 8'h30;
  localparam logic [7:0] MODE_QUERY        = 8'h98;

  localparam logic [7:0] QUERY_LEN = 8'h52;

  // Strobes and selection handed from control to datapath.
  typedef struct packed {
    logic        capture;
    logic        useArray;
    logic [31:0] fixedVal;
  } rd_ctrl_t;

  // Query table contents, computed from geometry.
  function automatic logic [7:0] queryByte(input logic [7:0] idx,
                                           input int chipLog2,
                                           input int sectorCount,
                                           input int sectorBytes);
    logic [7:0] v;
    int cntM1;
    cntM1 = sectorCount - 1;
    case (idx)
      8'h10: v = 8'h51;
      8'h11: v = 8'h52;
      8'h12: v = 8'h59;
      8'h13: v = 8'h02;
      8'h15: v = 8'h31;
      8'h1B: v = 8'h27;
      8'h1C: v = 8'h36;
      8'h1F: v = 8'h07;
      8'h21: v = 8'h09;
      8'h22: v = 8'h0C;
      8'h23: v = 8'h01;
      8'h25: v = 8'h0A;
      8'h26: v = 8'h0D;
      8'h27: v = 8'(chipLog2);
      8'h28: v = 8'h02;
      8'h2C: v = 8'h01;
      8'h2D: v = 8'(cntM1);
      8'h2E: v = 8'(cntM1 >> 8);
      8'h2F: v = 8'(sectorBytes >> 8);
      8'h30: v = 8'(sectorBytes >> 16);
      8'h31: v = 8'h50;
      8'h32: v = 8'h52;
      8'h33: v = 8'h49;
      8'h34: v = 8'h31;
      8'h35: v = 8'h30;
      default: v = 8'h00;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/nor_rd_ctrl.sv
module nor_rd_ctrl
  import nor_rd_pkg::*;
#(
  parameter int DEV_BYTES    = 2,
  parameter int SECTOR_BYTES = 4096,
  parameter int SECTOR_COUNT = 16
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           rdEn,
  input  logic [7:0]     rdAddrLow,
  input  logic [7:0]     modeCode,
  input  logic [15:0]    idWord0,
  input  logic [15:0]    idWord1,
  input  logic [15:0]    idWord2,
  input  logic [15:0]    idWord3,
  input  logic           statusLoadEn,
  input  logic [7:0]     statusLoadVal,
  input  logic           busyDone,
  output rd_ctrl_t       ctrl,
  output logic           modeClear
);

  localparam int OFF_SHIFT  = (DEV_BYTES == 4) ? 2 : ((DEV_BYTES == 2) ? 1 : 0);
  localparam int CHIP_LOG2  = $clog2(SECTOR_BYTES * SECTOR_COUNT);

  logic [7:0] regOffset;
  logic [7:0] statusQ;
  logic       statusHit;
  logic       unknownMode;
  logic       useArray;
  logic [31:0] fixedVal;

  assign regOffset = rdAddrLow >> OFF_SHIFT;

  always_comb begin
    useArray    = 1'b0;
    fixedVal    = 32'h0;
    statusHit   = 1'b0;
    unknownMode = 1'b0;
    case (modeCode)
      MODE_READ, MODE_ERASE_SETUP: useArray = 1'b1;
      MODE_AUTOSEL: begin
        case (regOffset)
          8'h00: fixedVal = {16'h0, idWord0};
          8'h01: fixedVal = {16'h0, idWord1};
          8'h02: fixedVal = 32'h0;
          8'h0E: begin
            if (idWord2[7:0] == 8'hFF) useArray = 1'b1;
            else                       fixedVal = {16'h0, idWord2};
          end
          8'h0F: begin
            if (idWord3[7:0] == 8'hFF) useArray = 1'b1;
            else                       fixedVal = {16'h0, idWord3};
          end
          default: useArray = 1'b1;
        endcase
      end
      MODE_PROGRAM, MODE_CHIP_ERASE, MODE_SECTOR_ERASE: begin
        fixedVal  = {24'h0, statusQ};
        statusHit = 1'b1;
      end
      MODE_QUERY: begin
        if (regOffset < QUERY_LEN)
          fixedVal = {24'h0, queryByte(regOffset, CHIP_LOG2, SECTOR_COUNT, SECTOR_BYTES)};
        else
          fixedVal = 32'h0;
      end
      default: begin
        useArray    = 1'b1;
        unknownMode = 1'b1;
      end
    endcase
  end

  assign ctrl.capture  = rdEn;
  assign ctrl.useArray = useArray;
  assign ctrl.fixedVal = fixedVal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ   <= 8'h00;
      modeClear <= 1'b0;
    end else begin
      modeClear <= rdEn && unknownMode;
      if (statusLoadEn)
        statusQ <= statusLoadVal;
      else
        statusQ <= statusQ ^ {busyDone, rdEn && statusHit, 6'b0};
    end
  end

endmodule

// File: rtl/nor_rd_datapath.sv
module nor_rd_datapath
  import nor_rd_pkg::*;
#(
  parameter int CHIP_AW = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  rd_ctrl_t           ctrl,
  input  logic [CHIP_AW-1:0] chipAddr,
  input  logic [1:0]         rdSize,
  input  logic               bigEndian,
  input  logic [31:0]        arrData,
  output logic               arrRdEn,
  output logic [CHIP_AW-1:0] arrAddr,
  output logic [31:0]        rdData,
  output logic               rdValid
);

  localparam int LANES = 4;

  logic        useArrayQ;
  logic [31:0] fixedQ;
  logic [1:0]  sizeQ;
  logic        beQ;
  logic [7:0]  arrByte [LANES];
  logic [31:0] assembled;

  assign arrRdEn = ctrl.capture;
  assign arrAddr = chipAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid   <= 1'b0;
      useArrayQ <= 1'b0;
      fixedQ    <= 32'h0;
      sizeQ     <= 2'd0;
      beQ       <= 1'b0;
    end else begin
      rdValid <= ctrl.capture;
      if (ctrl.capture) begin
        useArrayQ <= ctrl.useArray;
        fixedQ    <= ctrl.fixedVal;
        sizeQ     <= rdSize;
        beQ       <= bigEndian;
      end
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_split
    assign arrByte[i] = arrData[8*i +: 8];
  end

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    localparam int HALF_BE = (j < 2) ? (1 - j) : 0;
    localparam int WORD_BE = LANES - 1 - j;
    logic [7:0] laneByte;
    always_comb begin
      case (sizeQ)
        2'd0:    laneByte = (j == 0) ? arrByte[0] : 8'h00;
        2'd1:    laneByte = (j < 2) ? (beQ ? arrByte[HALF_BE] : arrByte[j]) : 8'h00;
        default: laneByte = beQ ? arrByte[WORD_BE] : arrByte[j];
      endcase
    end
    assign assembled[8*j +: 8] = laneByte;
  end

  assign rdData = useArrayQ ? assembled : fixedQ;

endmodule

// File: rtl/nor_read_mux.sv
module nor_read_mux
  import nor_rd_pkg::*;
#(
  parameter int ADDR_W       = 20,
  parameter int SECTOR_BYTES = 4096,
  parameter int SECTOR_COUNT = 16,
  parameter int DEV_BYTES    = 2,
  localparam int CHIP_BYTES  = SECTOR_BYTES * SECTOR_COUNT,
  localparam int CHIP_AW     = $clog2(CHIP_BYTES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rdEn,
  input  logic [ADDR_W-1:0]  rdAddr,
  input  logic [1:0]         rdSize,
  input  logic               bigEndian,
  input  logic [7:0]         modeCode,
  input  logic [15:0]        idWord0,
  input  logic [15:0]        idWord1,
  input  logic [15:0]        idWord2,
  input  logic [15:0]        idWord3,
  input  logic               statusLoadEn,
  input  logic [7:0]         statusLoadVal,
  input  logic               busyDone,
  output logic               arrRdEn,
  output logic [CHIP_AW-1:0] arrAddr,
  input  logic [31:0]        arrData,
  output logic [31:0]        rdData,
  output logic               rdValid,
  output logic               modeClear
);

  rd_ctrl_t           ctrl;
  logic [CHIP_AW-1:0] chipAddr;

  // Mirror the chip across the bus window: keep only the chip-size bits.
  assign chipAddr = rdAddr[CHIP_AW-1:0];

  if (ADDR_W > CHIP_AW) begin : g_hi
    logic unusedAddrHi;
    assign unusedAddrHi = ^rdAddr[ADDR_W-1:CHIP_AW];
  end

  nor_rd_ctrl #(
    .DEV_BYTES   (DEV_BYTES),
    .SECTOR_BYTES(SECTOR_BYTES),
    .SECTOR_COUNT(SECTOR_COUNT)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .rdEn         (rdEn),
    .rdAddrLow    (rdAddr[7:0]),
    .modeCode     (modeCode),
    .idWord0      (idWord0),
    .idWord1      (idWord1),
    .idWord2      (idWord2),
    .idWord3      (idWord3),
    .statusLoadEn (statusLoadEn),
    .statusLoadVal(statusLoadVal),
    .busyDone     (busyDone),
    .ctrl         (ctrl),
    .modeClear    (modeClear)
  );

  nor_rd_datapath #(
    .CHIP_AW(CHIP_AW)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .chipAddr (chipAddr),
    .rdSize   (rdSize),
    .bigEndian(bigEndian),
    .arrData  (arrData),
    .arrRdEn  (arrRdEn),
    .arrAddr  (arrAddr),
    .rdData   (rdData),
    .rdValid  (rdValid)
  );

endmodule

// File: rtl/nor_read_mux_chk.sv
module nor_read_mux_chk #(
  parameter int DEV_BYTES = 2
) (
  input logic        clk,
  input logic        rstN,
  input logic        rdEn,
  input logic [7:0]  rdAddrLow,
  input logic [7:0]  modeCode,
  input logic        statusLoadEn,
  input logic        busyDone,
  input logic [31:0] rdData,
  input logic        rdValid,
  input logic        modeClear
);

  localparam int OFF_SHIFT = (DEV_BYTES == 4) ? 2 : ((DEV_BYTES == 2) ? 1 : 0);

  logic [7:0] offs;
  logic       statusPoll;
  logic       knownMode;

  assign offs       = rdAddrLow >> OFF_SHIFT;
  assign statusPoll = rdEn && !statusLoadEn && !busyDone &&
                      (modeCode == 8'hA0 || modeCode == 8'h10 || modeCode == 8'h30);
  assign knownMode  = modeCode == 8'h00 || modeCode == 8'h80 || modeCode == 8'h90 ||
                      modeCode == 8'hA0 || modeCode == 8'h10 || modeCode == 8'h30 ||
                      modeCode == 8'h98;

  assert_valid_after_read_R1: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid);

  assert_no_valid_without_read_R1: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> !rdValid);

  assert_protect_word_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && modeCode == 8'h90 && offs == 8'h02) |=> rdData == 32'h0);

  assert_status_byte_wide_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && (modeCode == 8'hA0 || modeCode == 8'h10 || modeCode == 8'h30))
      |=> rdData[31:8] == 24'h0);

  assert_status_bit6_flips_R7: assert property (@(posedge clk) disable iff (!rstN)
    statusPoll ##1 statusPoll |=> rdData[6] != $past(rdData[6]));

  assert_query_tail_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && modeCode == 8'h98 && offs >= 8'h52) |=> rdData == 32'h0);

  assert_unknown_clears_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !knownMode) |=> modeClear);

  assert_clear_only_on_read_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!rdEn || knownMode) |=> !modeClear);

endmodule

bind nor_read_mux nor_read_mux_chk #(.DEV_BYTES(DEV_BYTES)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .rdEn        (rdEn),
  .rdAddrLow   (rdAddr[7:0]),
  .modeCode    (modeCode),
  .statusLoadEn(statusLoadEn),
  .busyDone    (busyDone),
  .rdData      (rdData),
  .rdValid     (rdValid),
  .modeClear   (modeClear)
);

// File: tb/nor_read_mux_tb.sv
module nor_read_mux_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 20;
  localparam int CHIP_AW    = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              rdEn = 1'b0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [1:0]        rdSize = 2'd0;
  logic              bigEndian = 1'b0;
  logic [7:0]        modeCode = 8'h00;
  logic [15:0]       idWord0 = 16'h00C2;
  logic [15:0]       idWord1 = 16'h227E;
  logic [15:0]       idWord2 = 16'h2201;
  logic [15:0]       idWord3 = 16'h00FF;
  logic              statusLoadEn = 1'b0;
  logic [7:0]        statusLoadVal = 8'h00;
  logic              busyDone = 1'b0;
  logic              arrRdEn;
  logic [CHIP_AW-1:0] arrAddr;
  logic [31:0]       arrData = 32'h0;
  logic [31:0]       rdData;
  logic              rdValid;
  logic              modeClear;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nor_read_mux u_dut (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdAddr(rdAddr), .rdSize(rdSize),
    .bigEndian(bigEndian), .modeCode(modeCode), .idWord0(idWord0),
    .idWord1(idWord1), .idWord2(idWord2), .idWord3(idWord3),
    .statusLoadEn(statusLoadEn), .statusLoadVal(statusLoadVal),
    .busyDone(busyDone), .arrRdEn(arrRdEn), .arrAddr(arrAddr),
    .arrData(arrData), .rdData(rdData), .rdValid(rdValid), .modeClear(modeClear)
  );

  // Array content is a function of the byte address, so no storage is needed.
  function automatic logic [7:0] memByte(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
  endfunction

  always @(posedge clk) begin
    if (arrRdEn)
      arrData <= {memByte(arrAddr + 16'd3), memByte(arrAddr + 16'd2),
                  memByte(arrAddr + 16'd1), memByte(arrAddr)};
  end

  function automatic logic [31:0] expArray(input logic [ADDR_W-1:0] addr,
                                           input logic [1:0] sz, input logic be);
    logic [15:0] a;
    logic [7:0] b0, b1, b2, b3;
    a  = addr[15:0];
    b0 = memByte(a);
    b1 = memByte(a + 16'd1);
    b2 = memByte(a + 16'd2);
    b3 = memByte(a + 16'd3);
    if (sz == 2'd0)      return {24'h0, b0};
    else if (sz == 2'd1) return be ? {16'h0, b0, b1} : {16'h0, b1, b0};
    else                 return be ? {b0, b1, b2, b3} : {b3, b2, b1, b0};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a falling edge; result sampled one falling edge later.
  task automatic doRead(input logic [7:0] mode, input logic [ADDR_W-1:0] addr,
                        input logic [1:0] sz, input logic be,
                        output logic [31:0] data, output logic clr);
    modeCode  = mode;
    rdAddr    = addr;
    rdSize    = sz;
    bigEndian = be;
    rdEn      = 1'b1;
    @(negedge clk);
    check("R1", {31'h0, rdValid}, 32'h1);
    data = rdData;
    clr  = modeClear;
    rdEn = 1'b0;
  endtask

  task automatic testReset();
    check("R11", {31'h0, rdValid}, 32'h0);
    check("R11", {31'h0, modeClear}, 32'h0);
    @(negedge clk);
    check("R1", {31'h0, rdValid}, 32'h0);
  endtask

  task automatic testArray();
    logic [31:0] d;
    logic c;
    for (int s = 0; s < 3; s++) begin
      for (int e = 0; e < 2; e++) begin
        doRead(8'h00, 20'h0_1234 + 20'(s * 17), 2'(s), 1'(e), d, c);
        check("R2", d, expArray(20'h0_1234 + 20'(s * 17), 2'(s), 1'(e)));
      end
    end
    doRead(8'h80, 20'h0_0F0E, 2'd2, 1'b1, d, c);
    check("R2", d, expArray(20'h0_0F0E, 2'd2, 1'b1));
    doRead(8'h00, 20'h0_2000, 2'd3, 1'b0, d, c);
    check("R2", d, expArray(20'h0_2000, 2'd3, 1'b0));
  endtask

  task automatic testMirror();
    logic [31:0] d;
    logic c;
    doRead(8'h00, 20'h3_0456, 2'd2, 1'b0, d, c);
    check("R3", d, expArray(20'h0_0456, 2'd2, 1'b0));
    doRead(8'h00, 20'hF_FFFE, 2'd1, 1'b1, d, c);
    check("R3", d, expArray(20'h0_FFFE, 2'd1, 1'b1));
  endtask

  task automatic testIds();
    logic [31:0] d;
    logic c;
    doRead(8'h90, 20'h0_0000, 2'd1, 1'b0, d, c);
    check("R5", d, {16'h0, idWord0});
    doRead(8'h90, 20'h0_0002, 2'd1, 1'b0, d, c);
    check("R5", d, {16'h0, idWord1});
    doRead(8'h90, 20'h0_0003, 2'd1, 1'b0, d, c);   // R4: odd byte, same offset 1
    check("R4", d, {16'h0, idWord1});
    doRead(8'h90, 20'h0_0004, 2'd1, 1'b0, d, c);
    check("R5", d, 32'h0);
    doRead(8'h90, 20'h0_001C, 2'd1, 1'b0, d, c);
    check("R6", d, {16'h0, idWord2});
    doRead(8'h90, 20'h0_001E, 2'd1, 1'b0, d, c);   // idWord3 low byte 0xFF
    check("R6", d, expArray(20'h0_001E, 2'd1, 1'b0));
    idWord3 = 16'h1234;
    doRead(8'h90, 20'h0_001E, 2'd1, 1'b0, d, c);
    check("R6", d, 32'h0000_1234);
    idWord2 = 16'hABFF;
    doRead(8'h90, 20'h0_001C, 2'd2, 1'b1, d, c);
    check("R6", d, expArray(20'h0_001C, 2'd2, 1'b1));
    doRead(8'h90, 20'h0_000A, 2'd1, 1'b0, d, c);
    check("R6", d, expArray(20'h0_000A, 2'd1, 1'b0));
  endtask

  task automatic testStatus();
    logic [31:0] d;
    logic c;
    doRead(8'hA0, 20'h0_0100, 2'd1, 1'b0, d, c);
    check("R8", d, 32'h00);          // reset value
    doRead(8'hA0, 20'h0_0100, 2'd1, 1'b0, d, c);
    check("R7", d, 32'h40);
    doRead(8'h10, 20'h0_0200, 2'd2, 1'b0, d, c);
    check("R7", d, 32'h00);
    doRead(8'h30, 20'h0_0300, 2'd0, 1'b1, d, c);
    check("R7", d, 32'h40);
    // status is now 0x00; load 0x13
    statusLoadEn = 1'b1; statusLoadVal = 8'h13;
    @(negedge clk);
    statusLoadEn = 1'b0;
    doRead(8'h30, 20'h0_0000, 2'd1, 1'b0, d, c);
    check("R8", d, 32'h13);          // afterwards 0x53
    busyDone = 1'b1;
    @(negedge clk);
    busyDone = 1'b0;                  // 0xD3
    doRead(8'h30, 20'h0_0000, 2'd1, 1'b0, d, c);
    check("R8", d, 32'hD3);          // afterwards 0x93
    // load wins over a simultaneous poll toggle
    statusLoadEn = 1'b1; statusLoadVal = 8'h05;
    doRead(8'hA0, 20'h0_0000, 2'd1, 1'b0, d, c);
    statusLoadEn = 1'b0;
    check("R7", d, 32'h93);
    doRead(8'hA0, 20'h0_0000, 2'd1, 1'b0, d, c);
    check("R8", d, 32'h05);
  endtask

  task automatic testQuery();
    logic [31:0] d;
    logic c;
    doRead(8'h98, 20'h0_0020, 2'd1, 1'b0, d, c);
    check("R9", d, 32'h51);
    doRead(8'h98, 20'h0_004E, 2'd1, 1'b0, d, c);
    check("R9", d, 32'h10);
    doRead(8'h98, 20'h0_0058, 2'd1, 1'b0, d, c);
    check("R9", d, 32'h01);
    doRead(8'h98, 20'h0_005A, 2'd1, 1'b0, d, c);
    check("R9", d, 32'h0F);
    doRead(8'h98, 20'h0_00A2, 2'd1, 1'b0, d, c);
    check("R9", d, 32'h00);
    doRead(8'h98, 20'h0_00A4, 2'd1, 1'b0, d, c);
    check("R9", d, 32'h00);
    doRead(8'h98, 20'h0_00FE, 2'd1, 1'b0, d, c);
    check("R9", d, 32'h00);
  endtask

  task automatic testUnknown();
    logic [31:0] d;
    logic c;
    doRead(8'h55, 20'h0_0040, 2'd2, 1'b0, d, c);
    check("R10", d, expArray(20'h0_0040, 2'd2, 1'b0));
    check("R10", {31'h0, c}, 32'h1);
    doRead(8'h00, 20'h0_0040, 2'd2, 1'b0, d, c);
    check("R10", {31'h0, c}, 32'h0);
    @(negedge clk);
    check("R10", {31'h0, modeClear}, 32'h0);
    check("R1", {31'h0, rdValid}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testArray();
    testMirror();
    testIds();
    testStatus();
    testQuery();
    testUnknown();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule